// File: doc/BRIEF.md
# Video Control Line Deglitcher

This block cleans up the three slow video timing lines (data enable, horizontal sync and vertical sync) on the pixel clock before they drive a display. Each line is registered on entry. A change of level reaches the output only after the new level has been seen for enough consecutive cycles. A separate transition budget then limits how many output edges a line may produce inside any 130-cycle span. Single- and double-cycle spikes on data enable and horizontal sync therefore never reach the panel. Vertical sync must hold a new level for a full 130 cycles before it is accepted.

A registered filter-enable input chooses between qualified and unqualified behaviour for data enable and horizontal sync. With the filter off, those two lines pass any pulse, however short, through a delay line whose length matches the qualification time, so output timing does not depend on the mode. The transition budget applies in both modes. Vertical sync is always qualified. A transition held back by an exhausted budget is deferred: it is committed in the first cycle the budget allows, provided the input still shows the new level, and it is dropped otherwise.

Top module: `vidctl_deglitch`

## Requirements
- R1: With filterEn=1, a data-enable or horizontal-sync output changes only after the input has held the new level for at least 3 consecutive sampled cycles. Pulses of 1 or 2 cycles, of either polarity, leave the output at its previous level.
- R2: With filterEn=1 and budget available, an input change on data enable or horizontal sync that is first sampled at rising edge n appears on the output just after edge n+3. A pulse of 3 or more cycles is reproduced with its width unchanged.
- R3: With filterEn=0, data enable and horizontal sync pass pulses of any width, including a single cycle, with the same edge n to edge n+3 timing as in R2.
- R4: Data enable and horizontal sync each produce at most 2 output transitions in any 130 consecutive cycles. A blocked transition is committed at the first edge the budget permits if the input still holds the new level, and is discarded if the input has returned to the output level by then.
- R5: The R4 budget also applies with filterEn=0. A blocked single-cycle pulse is lost, and a level held after the window has expired passes normally.
- R6: Vertical sync ignores filterEn. It changes only after 130 consecutive sampled cycles at the new level, just after edge n+130 for a change first sampled at edge n. A pulse of 129 cycles is rejected.
- R7: Vertical sync produces at most 1 output transition in any 130 consecutive cycles.
- R8: A synchronous active-high rst drives all three outputs low and clears all qualification and budget state, so a level present after release is accepted with R2 timing.
- R9: Each line keeps its own qualification and budget. Data enable spending its budget does not delay a horizontal-sync transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| filterEn | input | 1 | 1 = qualify data enable and horizontal sync, 0 = delay only; registered |
| deIn | input | 1 | Raw data enable |
| hsIn | input | 1 | Raw horizontal sync |
| vsIn | input | 1 | Raw vertical sync |
| deOut | output | 1 | Cleaned data enable |
| hsOut | output | 1 | Cleaned horizontal sync |
| vsOut | output | 1 | Cleaned vertical sync |

## Verification
The hardest state to reach is a qualified transition that waits on an exhausted budget, because it needs two committed edges inside the window followed by a third valid level. The stimulus spends the budget with a rise and a fall about ten cycles apart, then holds a new level and expects it exactly 130 cycles after the first committed edge. It repeats the sequence with the level withdrawn before the window closes, so the deferred edge is expected to vanish. Pulse widths from 1 to 5 are swept on both fast lines, with gaps long enough that the budget never interferes, so every output sample follows from the width alone.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  localparam int NLINES  = 3;
  localparam int LINE_DE = 0;
  localparam int LINE_HS = 1;
  localparam int LINE_VS = 2;

  // Commit strobes from control to datapath: one bit per line, toggles that line's output level.
  typedef struct packed {
    logic [NLINES-1:0] flip;
  } strobe_t;
endpackage

// File: rtl/vidctl_deglitch_ctrl.sv
module vidctl_deglitch_ctrl
  import vidctl_pkg::*;
#(
  parameter int SHORT_HOLD  = 3,
  parameter int LONG_HOLD   = 130,
  parameter int WINDOW      = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeOn,
  input  logic [NLINES-1:0] obs,
  input  logic [NLINES-1:0] level,
  output strobe_t           strb
);
  localparam int CW = $clog2(LONG_HOLD + 1);
  localparam int SW = $clog2(WINDOW + 1);

  logic [NLINES-1:0] flipVec;

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    localparam bit SLOW = (gi == LINE_VS);
    localparam int BUD  = SLOW ? SLOW_BUDGET : FAST_BUDGET;

    logic [CW-1:0]  run;
    logic [CW-1:0]  need;
    logic [SW-1:0]  slot [BUD];
    logic [BUD-1:0] pickOh;
    logic           differ;
    logic           ready;
    logic           freeAny;

    // Required hold time: long for the slow line, short or one cycle for fast lines.
    always_comb begin
      if (SLOW)        need = CW'(LONG_HOLD);
      else if (modeOn) need = CW'(SHORT_HOLD);
      else             need = CW'(1);
    end

    assign differ = obs[gi] ^ level[gi];
    assign ready  = differ && (run >= need - CW'(1));

    // First idle budget slot, if any.
    always_comb begin
      pickOh  = '0;
      freeAny = 1'b0;
      for (int j = 0; j < BUD; j++) begin
        if (!freeAny && slot[j] == '0) begin
          pickOh[j] = 1'b1;
          freeAny   = 1'b1;
        end
      end
    end

    assign flipVec[gi] = ready && freeAny;

    // Stability counter: counts cycles of disagreement, saturates once ready.
    always_ff @(posedge clk) begin
      if (rst)                       run <= '0;
      else if (!differ || flipVec[gi]) run <= '0;
      else if (!ready)               run <= run + CW'(1);
    end

    // Budget slots: each holds the cycles left before a committed edge leaves the window.
    always_ff @(posedge clk) begin
      for (int j = 0; j < BUD; j++) begin
        if (rst)                           slot[j] <= '0;
        else if (flipVec[gi] && pickOh[j]) slot[j] <= SW'(WINDOW - 1);
        else if (slot[j] != '0)            slot[j] <= slot[j] - SW'(1);
      end
    end
  end

  assign strb.flip = flipVec;
endmodule

// File: rtl/vidctl_deglitch_dp.sv
module vidctl_deglitch_dp
  import vidctl_pkg::*;
#(
  parameter int SHORT_HOLD  = 3,
  parameter int LONG_HOLD   = 130,
  parameter int WINDOW      = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              filterEn,
  input  logic [NLINES-1:0] lineIn,
  input  strobe_t           strb,
  output logic              modeOn,
  output logic [NLINES-1:0] obs,
  output logic [NLINES-1:0] level
);
  localparam int DLYN = SHORT_HOLD - 1;
  localparam int AW   = $clog2(WINDOW + 1);
  localparam int CW   = $clog2(LONG_HOLD + 1);

  logic [NLINES-1:0] samp;
  logic [1:0]        dly [DLYN];

  always_ff @(posedge clk) begin
    if (rst) begin
      modeOn <= 1'b0;
      samp   <= '0;
    end else begin
      modeOn <= filterEn;
      samp   <= lineIn;
    end
  end

  // Delay line for the fast lines, so bypass timing equals qualified timing.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DLYN; k++) dly[k] <= '0;
    end else begin
      dly[0] <= samp[LINE_HS:LINE_DE];
      for (int k = 1; k < DLYN; k++) dly[k] <= dly[k-1];
    end
  end

  always_comb begin
    obs[LINE_HS:LINE_DE] = modeOn ? samp[LINE_HS:LINE_DE] : dly[DLYN-1];
    obs[LINE_VS]         = samp[LINE_VS];
  end

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= level ^ strb.flip;
  end

  // ---------------- checks ----------------
  AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> level == '0); // R8

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_chk
    localparam bit SLOW = (gi == LINE_VS);
    localparam int BUD  = SLOW ? SLOW_BUDGET : FAST_BUDGET;

    // Cycles since each of the last BUD commits, saturating at WINDOW.
    logic [AW-1:0] age [BUD];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < BUD; j++) age[j] <= AW'(WINDOW);
      end else if (strb.flip[gi]) begin
        age[0] <= '0;
        for (int j = 1; j < BUD; j++)
          age[j] <= (age[j-1] == AW'(WINDOW)) ? age[j-1] : age[j-1] + AW'(1);
      end else begin
        for (int j = 0; j < BUD; j++)
          if (age[j] != AW'(WINDOW)) age[j] <= age[j] + AW'(1);
      end
    end

    if (SLOW) begin : g_slow
      AST_SLOW_BUDGET: assert property (@(posedge clk) disable iff (rst)
        strb.flip[gi] |-> age[BUD-1] >= AW'(WINDOW - 1)); // R7
    end else begin : g_fast
      AST_FAST_BUDGET: assert property (@(posedge clk) disable iff (rst)
        strb.flip[gi] |-> age[BUD-1] >= AW'(WINDOW - 1)); // R4
      AST_HOLD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (level[gi] != $past(level[gi])) && $past(modeOn, 1) && $past(modeOn, 2)
          && $past(modeOn, 3) && $past(modeOn, 4)
        |-> ($past(samp[gi], 1) == level[gi]) && ($past(samp[gi], 2) == level[gi])
          && ($past(samp[gi], 3) == level[gi])); // R1
      AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (rst)
        (level[gi] != $past(level[gi])) && !$past(modeOn, 1)
        |-> $past(samp[gi], 3) == level[gi]); // R3
    end
  end

  logic [CW-1:0] vsRun;
  always_ff @(posedge clk) begin
    if (rst)                                  vsRun <= '0;
    else if (samp[LINE_VS] != level[LINE_VS]) vsRun <= (vsRun == CW'(LONG_HOLD)) ? vsRun : vsRun + CW'(1);
    else                                      vsRun <= '0;
  end

  AST_VS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (level[LINE_VS] != $past(level[LINE_VS]))
    |-> ($past(vsRun) >= CW'(LONG_HOLD - 1)) && ($past(samp[LINE_VS]) == level[LINE_VS])); // R6
endmodule

// File: rtl/vidctl_deglitch.sv
module vidctl_deglitch
  import vidctl_pkg::*;
#(
  parameter int SHORT_HOLD  = 3,
  parameter int LONG_HOLD   = 130,
  parameter int WINDOW      = 130,
  parameter int FAST_BUDGET = 2,
  parameter int SLOW_BUDGET = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic filterEn,
  input  logic deIn,
  input  logic hsIn,
  input  logic vsIn,
  output logic deOut,
  output logic hsOut,
  output logic vsOut
);
  strobe_t           strb;
  logic              modeOn;
  logic [NLINES-1:0] obs;
  logic [NLINES-1:0] level;
  logic [NLINES-1:0] lineIn;

  always_comb begin
    lineIn          = '0;
    lineIn[LINE_DE] = deIn;
    lineIn[LINE_HS] = hsIn;
    lineIn[LINE_VS] = vsIn;
  end

  vidctl_deglitch_dp #(
    .SHORT_HOLD(SHORT_HOLD), .LONG_HOLD(LONG_HOLD), .WINDOW(WINDOW),
    .FAST_BUDGET(FAST_BUDGET), .SLOW_BUDGET(SLOW_BUDGET)
  ) dp_i (
    .clk(clk), .rst(rst), .filterEn(filterEn), .lineIn(lineIn),
    .strb(strb), .modeOn(modeOn), .obs(obs), .level(level)
  );

  vidctl_deglitch_ctrl #(
    .SHORT_HOLD(SHORT_HOLD), .LONG_HOLD(LONG_HOLD), .WINDOW(WINDOW),
    .FAST_BUDGET(FAST_BUDGET), .SLOW_BUDGET(SLOW_BUDGET)
  ) ctrl_i (
    .clk(clk), .rst(rst), .modeOn(modeOn), .obs(obs), .level(level), .strb(strb)
  );

  assign deOut = level[LINE_DE];
  assign hsOut = level[LINE_HS];
  assign vsOut = level[LINE_VS];
endmodule

// File: tb/vidctl_deglitch_tb_top.sv
module vidctl_deglitch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst, filterEn, deIn, hsIn, vsIn;
  logic deOut, hsOut, vsOut;
  int   cyc   = 0;
  int   total = 0;
  int   fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vidctl_deglitch dut_i (
    .clk(clk), .rst(rst), .filterEn(filterEn),
    .deIn(deIn), .hsIn(hsIn), .vsIn(vsIn),
    .deOut(deOut), .hsOut(hsOut), .vsOut(vsOut)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic waitTo(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic setLine(input int ln, input logic v);
    if (ln == 0)      deIn = v;
    else if (ln == 1) hsIn = v;
    else              vsIn = v;
  endtask

  function automatic logic outOf(input int ln);
    if (ln == 0)      return deOut;
    else if (ln == 1) return hsOut;
    else              return vsOut;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int c;
    rst = 1'b1; filterEn = 1'b1; deIn = 1'b0; hsIn = 1'b0; vsIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8", "deOut in reset", deOut, 1'b0);
    chk("R8", "hsOut in reset", hsOut, 1'b0);
    chk("R8", "vsOut in reset", vsOut, 1'b0);
    rst = 1'b0;
    waitTo(cyc + 5);

    // R1/R2 sweep: pulse widths 1..5 on both fast lines, filter on.
    for (int ln = 0; ln < 2; ln++) begin
      for (int w = 1; w <= 5; w++) begin
        c = cyc;
        setLine(ln, 1'b1);
        for (int t = c + 1; t <= c + w + 6; t++) begin
          waitTo(t);
          chk((w >= 3) ? "R2" : "R1", "sweep pulse", outOf(ln),
              (w >= 3) && (t >= c + 4) && (t < c + w + 4));
          if (t == c + w) setLine(ln, 1'b0);
        end
        waitTo(c + w + 140);
      end
    end

    // R1: inverted 2-cycle glitch on a high horizontal sync.
    c = cyc;
    hsIn = 1'b1;
    waitTo(c + 4);  chk("R2", "hs rise", hsOut, 1'b1);
    waitTo(c + 10); hsIn = 1'b0;
    waitTo(c + 12); hsIn = 1'b1;
    for (int t = c + 13; t <= c + 20; t++) begin
      waitTo(t);
      chk("R1", "low glitch kept out", hsOut, 1'b1);
    end
    waitTo(c + 150);

    // R4 deferral and R9 independence, filter on.
    c = cyc;
    deIn = 1'b1;
    waitTo(c + 4);  chk("R4", "first edge", deOut, 1'b1);
    waitTo(c + 10); deIn = 1'b0;
    waitTo(c + 14); chk("R4", "second edge", deOut, 1'b0);
    waitTo(c + 20); deIn = 1'b1;
    waitTo(c + 24); chk("R4", "third edge blocked", deOut, 1'b0);
    waitTo(c + 30); hsIn = 1'b0;
    waitTo(c + 33); chk("R9", "hs before edge", hsOut, 1'b1);
    waitTo(c + 34); chk("R9", "hs not held by de budget", hsOut, 1'b0);
    waitTo(c + 133); chk("R4", "deferred edge not early", deOut, 1'b0);
    waitTo(c + 134); chk("R4", "deferred edge at window end", deOut, 1'b1);
    waitTo(c + 140); deIn = 1'b0;
    waitTo(c + 144); chk("R4", "fall when slot frees", deOut, 1'b0);
    waitTo(c + 146); deIn = 1'b1;
    waitTo(c + 150); chk("R4", "rise blocked", deOut, 1'b0);
    waitTo(c + 160); deIn = 1'b0;
    waitTo(c + 270); chk("R4", "withdrawn edge discarded", deOut, 1'b0);
    waitTo(c + 280);

    // R3/R5: bypass mode.
    filterEn = 1'b0;
    waitTo(c + 300);
    c = cyc;
    deIn = 1'b1;
    waitTo(c + 1); deIn = 1'b0;
    waitTo(c + 3); chk("R3", "1-cycle pulse latency", deOut, 1'b0);
    waitTo(c + 4); chk("R3", "1-cycle pulse high", deOut, 1'b1);
    waitTo(c + 5); chk("R3", "1-cycle pulse width", deOut, 1'b0);
    waitTo(c + 10); deIn = 1'b1;
    waitTo(c + 11); deIn = 1'b0;
    for (int t = c + 12; t <= c + 20; t++) begin
      waitTo(t);
      chk("R5", "pulse over budget lost", deOut, 1'b0);
    end
    waitTo(c + 140); deIn = 1'b1;
    waitTo(c + 143); chk("R5", "level after window", deOut, 1'b0);
    waitTo(c + 144); chk("R5", "level after window", deOut, 1'b1);
    waitTo(c + 150); deIn = 1'b0;
    waitTo(c + 154); chk("R3", "bypass fall", deOut, 1'b0);

    // R6: 129-cycle vertical sync rejected with filter off.
    waitTo(c + 300);
    c = cyc;
    vsIn = 1'b1;
    waitTo(c + 129); vsIn = 1'b0;
    waitTo(c + 130); chk("R6", "129-cycle vs rejected", vsOut, 1'b0);
    waitTo(c + 131); chk("R6", "129-cycle vs rejected", vsOut, 1'b0);
    waitTo(c + 140); chk("R6", "129-cycle vs rejected", vsOut, 1'b0);

    // R6/R7: 130-cycle vertical sync accepted with filter on.
    filterEn = 1'b1;
    waitTo(c + 300);
    c = cyc;
    vsIn = 1'b1;
    waitTo(c + 130); chk("R6", "vs before hold met", vsOut, 1'b0);
    waitTo(c + 131); chk("R6", "vs accepted", vsOut, 1'b1);
    vsIn = 1'b0;
    waitTo(c + 261); chk("R7", "vs second edge spacing", vsOut, 1'b1);
    waitTo(c + 262); chk("R7", "vs second edge", vsOut, 1'b0);

    // R8: reset mid-run.
    waitTo(c + 300);
    c = cyc;
    deIn = 1'b1;
    waitTo(c + 4);  chk("R8", "de high before reset", deOut, 1'b1);
    waitTo(c + 10); rst = 1'b1;
    waitTo(c + 11); chk("R8", "reset clears de", deOut, 1'b0);
    waitTo(c + 12); rst = 1'b0;
    waitTo(c + 15); chk("R8", "no early edge after reset", deOut, 1'b0);
    waitTo(c + 16); chk("R8", "level accepted after reset", deOut, 1'b1);
    chk("R8", "vs low after reset", vsOut, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule